// File: doc/BRIEF.md
# Timestamp-Gated Transmit Sample Buffer

This block sits in one transmit channel, between the host-facing packet stream and the interpolation chain that feeds a DAC. The write side takes a stream of 16-bit words. Each packet is four header words followed by its samples. The header gives a 32-bit launch time and a sample count. Every sample takes two words, first the in-phase part and then the quadrature part. The words go into a small random-access store, and the read side takes the words it needs from the current read pointer.

The launch time in a header is the moment the first sample must reach the converter. It is not the moment the sample enters the filter chain. For that reason the block subtracts a programmable pipeline latency from the stamp and compares the result with a free-running 32-bit time input. When the adjusted time arrives, the packet's samples come out one per transmit-clock enable. A packet whose adjusted time is already behind the time input when its header is read is dropped whole: the read pointer jumps over its sample words, nothing is emitted, and a drop counter steps. Time comparison is wraparound-safe, so packets remain correct when the counter rolls over from all ones to zero.

Top module: `ts_release_buf`

## Requirements
- R1: After reset `smp_valid` is 0, `drop_cnt` is 0 and `wr_ready` is 1.
- R2: A header is four words in this order: launch time bits 15:0, launch time bits 31:16, sample count, then a flags word. The flags word has no effect on timing, data or drop decisions.
- R3: If a packet is fully stored before its due time (launch time minus `pipe_lat`) and `tick` stays high, its first sample is presented in the cycle where `time_now` equals due time + 2. The remaining samples follow in consecutive cycles.
- R4: Each sample takes two stored words. The first word appears on `smp_i` and the second on `smp_q`, in the order the samples were written.
- R5: While a packet is playing and its words are present, one sample is presented in the cycle after each cycle with `tick` high, and none after a cycle with `tick` low.
- R6: If, when the header is read, the due time is earlier than `time_now` under a signed 32-bit difference, the packet produces no samples. Its sample words are discarded and `drop_cnt` increments by exactly 1.
- R7: Due-time comparison is modulo 2^32. A stamp just past the rollover counts as future when `time_now` is just below it, and a stamp just before the rollover counts as stale once `time_now` has wrapped.
- R8: `wr_ready` is 0 exactly when 2^ADDR_W words are stored. Words offered while it is 0 are not stored.
- R9: A packet with a count of 0 and a future stamp produces no output and does not change `drop_cnt`.
- R10: After the last sample of a packet the next header is read, and packets come out in write order, each with exactly its sample count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | 16 | Write word |
| wr_ready | output | 1 | Store can take a word |
| tick | input | 1 | Transmit-clock enable, one sample per high cycle |
| time_now | input | 32 | Free-running time count |
| pipe_lat | input | 16 | Downstream pipeline latency subtracted from each stamp |
| smp_valid | output | 1 | Sample presented this cycle |
| smp_i | output | 16 | In-phase part |
| smp_q | output | 16 | Quadrature part |
| drop_cnt | output | 16 | Count of packets dropped as stale |

## Verification
The bench builds the block with ADDR_W = 4, which gives a 16-word store. One six-sample packet plus the header of the next one is then enough to fill it, so the full-store stall, the ignored writes and the refill that follows are all reachable within a few dozen cycles. The bench controls the time input through an offset, which lets it start just below the 32-bit rollover and check both the future-across-wrap case and the stale-across-wrap case directly. Random packets vary the latency over 0 to 15, the count over 0 to 6 and the enable pattern, and mix in stale packets.

// File: rtl/ts_rel_pkg.sv
package ts_rel_pkg;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_WAIT,
    ST_SEND,
    ST_SKIP
  } rel_state_e;

  localparam int HDR_WORDS = 4;

  // Moment the first sample must enter the chain.
  function automatic logic [31:0] due_time(input logic [31:0] stamp, input logic [15:0] lat);
    return stamp - {16'd0, lat};
  endfunction

  // Signed distance from now to target; negative means target is past.
  function automatic logic signed [31:0] time_delta(input logic [31:0] target, input logic [31:0] now);
    return $signed(target - now);
  endfunction

endpackage

// File: rtl/ts_rel_store.sv
module ts_rel_store #(
  parameter int ADDR_W = 6,
  parameter int PEEK   = 3,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int OCC_W = ADDR_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [15:0]               wr_data,
  input  logic [OCC_W-1:0]          adv,
  output logic [OCC_W-1:0]          occ,
  output logic [PEEK-1:0][15:0]     peek
);

  logic [15:0]       mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr + ADDR_W'(wr_en);
      rd_ptr <= rd_ptr + adv[ADDR_W-1:0];
      occ    <= occ + OCC_W'(wr_en) - adv;
    end
  end

  // Random access ahead of the read pointer.
  for (genvar k = 0; k < PEEK; k++) begin : g_peek
    assign peek[k] = mem[rd_ptr + ADDR_W'(k)];
  end

endmodule

// File: rtl/ts_rel_ctrl.sv
module ts_rel_ctrl
  import ts_rel_pkg::*;
#(
  parameter int OCC_W  = 7,
  parameter int DROP_W = 16,
  localparam int SKIP_W = 17
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [31:0]           time_now,
  input  logic [15:0]           pipe_lat,
  input  logic [OCC_W-1:0]      occ,
  input  logic [2:0][15:0]      peek,
  output logic [OCC_W-1:0]      adv,
  output logic                  smp_valid,
  output logic [15:0]           smp_i,
  output logic [15:0]           smp_q,
  output logic [DROP_W-1:0]     drop_cnt,
  output logic                  ev_drop,
  output rel_state_e            st
);

  rel_state_e         nxt;
  logic [31:0]        due_q;
  logic [15:0]        left;
  logic [SKIP_W-1:0]  skip_left;

  logic [31:0]        hdr_stamp;
  logic [15:0]        hdr_count;
  logic [31:0]        hdr_due;
  logic signed [31:0] hdr_gap;
  logic signed [31:0] wait_gap;
  logic               hdr_here;
  logic               pair_here;
  logic               ev_fire;
  logic [SKIP_W-1:0]  occ_ext;
  logic [SKIP_W-1:0]  skip_take;

  assign hdr_stamp = {peek[1], peek[0]};
  assign hdr_count = peek[2];
  assign hdr_due   = due_time(hdr_stamp, pipe_lat);
  assign hdr_gap   = time_delta(hdr_due, time_now);
  assign wait_gap  = time_delta(due_q, time_now);
  assign hdr_here  = occ >= OCC_W'(HDR_WORDS);
  assign pair_here = occ >= OCC_W'(2);
  assign occ_ext   = SKIP_W'(occ);
  assign skip_take = (occ_ext < skip_left) ? occ_ext : skip_left;

  always_comb begin
    nxt     = st;
    adv     = '0;
    ev_drop = 1'b0;
    ev_fire = 1'b0;
    case (st)
      ST_HDR: begin
        if (hdr_here) begin
          adv = OCC_W'(HDR_WORDS);
          if (hdr_gap < 0) begin
            ev_drop = 1'b1;
            nxt     = ST_SKIP;
          end else if (hdr_count == 16'd0) begin
            nxt = ST_HDR;
          end else if (hdr_gap == 0) begin
            nxt = ST_SEND;
          end else begin
            nxt = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (wait_gap <= 0) nxt = ST_SEND;
      end
      ST_SEND: begin
        if (tick && pair_here) begin
          ev_fire = 1'b1;
          adv     = OCC_W'(2);
          if (left == 16'd1) nxt = ST_HDR;
        end
      end
      default: begin
        adv = OCC_W'(skip_take);
        if (skip_take == skip_left) nxt = ST_HDR;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      due_q     <= '0;
      left      <= '0;
      skip_left <= '0;
      smp_valid <= 1'b0;
      smp_i     <= '0;
      smp_q     <= '0;
      drop_cnt  <= '0;
    end else begin
      st        <= nxt;
      smp_valid <= ev_fire;
      if (st == ST_HDR && hdr_here) begin
        due_q     <= hdr_due;
        left      <= hdr_count;
        skip_left <= {hdr_count, 1'b0};
      end
      if (ev_fire) begin
        smp_i <= peek[0];
        smp_q <= peek[1];
        left  <= left - 16'd1;
      end
      if (st == ST_SKIP) skip_left <= skip_left - skip_take;
      if (ev_drop) drop_cnt <= drop_cnt + DROP_W'(1);
    end
  end

endmodule

// File: rtl/ts_release_buf.sv
module ts_release_buf
  import ts_rel_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int OCC_W = ADDR_W + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [15:0] wr_data,
  output logic        wr_ready,
  input  logic        tick,
  input  logic [31:0] time_now,
  input  logic [15:0] pipe_lat,
  output logic        smp_valid,
  output logic [15:0] smp_i,
  output logic [15:0] smp_q,
  output logic [15:0] drop_cnt
);

  logic [OCC_W-1:0]  occ;
  logic [OCC_W-1:0]  adv;
  logic [2:0][15:0]  peek;
  logic              wr_fire;
  logic              ev_drop;
  logic              waiting;
  rel_state_e        st;

  assign wr_ready = occ != OCC_W'(DEPTH);
  assign wr_fire  = wr_valid && wr_ready;
  assign waiting  = st == ST_WAIT;

  ts_rel_store #(.ADDR_W(ADDR_W), .PEEK(3)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_data (wr_data),
    .adv     (adv),
    .occ     (occ),
    .peek    (peek)
  );

  ts_rel_ctrl #(.OCC_W(OCC_W), .DROP_W(16)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .time_now  (time_now),
    .pipe_lat  (pipe_lat),
    .occ       (occ),
    .peek      (peek),
    .adv       (adv),
    .smp_valid (smp_valid),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .drop_cnt  (drop_cnt),
    .ev_drop   (ev_drop),
    .st        (st)
  );

endmodule

// File: rtl/ts_release_buf_chk.sv
module ts_release_buf_chk #(
  parameter int DEPTH = 64,
  parameter int OCC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             smp_valid,
  input logic [15:0]      drop_cnt,
  input logic [OCC_W-1:0] occ,
  input logic             ev_drop,
  input logic             waiting
);

  assert_sample_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(tick));

  assert_ready_low_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> occ == OCC_W'(DEPTH));

  assert_occ_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_blocked_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> occ <= $past(occ));

  assert_drop_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> drop_cnt == $past(drop_cnt) + 16'd1);

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !smp_valid);

  assert_wait_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> !smp_valid);

endmodule

bind ts_release_buf ts_release_buf_chk #(.DEPTH(1 << ADDR_W), .OCC_W(ADDR_W + 1)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .smp_valid (smp_valid),
  .drop_cnt  (drop_cnt),
  .occ       (occ),
  .ev_drop   (ev_drop),
  .waiting   (waiting)
);

// File: tb/ts_release_buf_bench.sv
module ts_release_buf_bench;

  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_ready;
  logic        tick = 1'b1;
  logic [31:0] time_now;
  logic [15:0] pipe_lat = '0;
  logic        smp_valid;
  logic [15:0] smp_i, smp_q, drop_cnt;

  logic [31:0] cyc = '0;
  logic [31:0] time_base = '0;
  int          tick_mode = 0;

  int nvec = 0;
  int nbad = 0;

  logic [15:0] cap_i [512];
  logic [15:0] cap_q [512];
  logic [31:0] cap_t [512];
  int          ncap = 0;
  int          last_base = 0;

  logic [15:0] pk_i [8];
  logic [15:0] pk_q [8];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 32'd1;
  assign time_now = cyc + time_base;

  ts_release_buf #(.ADDR_W(AW)) u_ts_release_buf (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .tick(tick), .time_now(time_now), .pipe_lat(pipe_lat), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .drop_cnt(drop_cnt)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench view of staleness: current time strictly ahead of due by less than half the range.
  function automatic bit is_stale(input logic [31:0] ts, input logic [15:0] lat, input logic [31:0] now);
    logic [31:0] behind;
    behind = now - (ts - {16'd0, lat});
    return (behind != 32'd0) && (behind < 32'h8000_0000);
  endfunction

  function automatic logic [31:0] first_at(input logic [31:0] ts, input logic [15:0] lat);
    return ts + 32'd2 - {16'd0, lat};
  endfunction

  initial forever begin
    @(negedge clk);
    if (rst_n && smp_valid && ncap < 512) begin
      cap_i[ncap] = smp_i;
      cap_q[ncap] = smp_q;
      cap_t[ncap] = time_now;
      ncap++;
    end
  end

  initial forever begin
    @(negedge clk);
    case (tick_mode)
      0:       tick = 1'b1;
      1:       tick = (time_now % 3 == 0);
      default: tick = 1'($urandom % 2);
    endcase
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  task automatic put_word(input logic [15:0] w);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic fill_samples(input int cnt);
    for (int k = 0; k < 8; k++) begin
      pk_i[k] = 16'($urandom);
      pk_q[k] = 16'($urandom);
    end
  endtask

  task automatic send_pkt(input logic [31:0] ts, input logic [15:0] cnt, input logic [15:0] flags);
    put_word(ts[15:0]);
    put_word(ts[31:16]);
    put_word(cnt);
    put_word(flags);
    for (int k = 0; k < int'(cnt); k++) begin
      put_word(pk_i[k]);
      put_word(pk_q[k]);
    end
  endtask

  task automatic run_pkt(input logic [31:0] ts, input logic [15:0] cnt, input logic [15:0] flags,
                         input string ctx, input bit exact);
    int  base;
    logic [15:0] drops0;
    bit  stale;
    logic [31:0] t0;
    base      = ncap;
    last_base = base;
    drops0    = drop_cnt;
    stale     = is_stale(ts, pipe_lat, time_now);
    fill_samples(int'(cnt));
    send_pkt(ts, cnt, flags);
    if (stale) begin
      repeat (2 * int'(cnt) + 10) @(negedge clk);
      check(ncap == base, {ctx, " R6 stale packet emitted"}, 32'(ncap - base), 32'd0);
      check(drop_cnt == drops0 + 16'd1, {ctx, " R6 drop count"}, 32'(drop_cnt), 32'(drops0 + 16'd1));
    end else if (cnt == 16'd0) begin
      repeat (12) @(negedge clk);
      check(ncap == base, {ctx, " R9 empty packet emitted"}, 32'(ncap - base), 32'd0);
      check(drop_cnt == drops0, {ctx, " R9 drop count"}, 32'(drop_cnt), 32'(drops0));
    end else begin
      for (int w = 0; w < 4000 && ncap < base + int'(cnt); w++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(ncap == base + int'(cnt), {ctx, " R10 sample count"}, 32'(ncap - base), 32'(cnt));
      for (int k = 0; k < int'(cnt); k++) begin
        check(cap_i[base + k] == pk_i[k], {ctx, " R4 in-phase word"}, 32'(cap_i[base + k]), 32'(pk_i[k]));
        check(cap_q[base + k] == pk_q[k], {ctx, " R4 quadrature word"}, 32'(cap_q[base + k]), 32'(pk_q[k]));
      end
      t0 = first_at(ts, pipe_lat);
      if (exact) begin
        check(cap_t[base] == t0, {ctx, " R3 first sample time"}, cap_t[base], t0);
        for (int k = 1; k < int'(cnt); k++)
          check(cap_t[base + k] == t0 + 32'(k), {ctx, " R3 consecutive samples"}, cap_t[base + k], t0 + 32'(k));
      end else begin
        check(!cap_t[base][31] ^ 1'b0 ? $signed(cap_t[base] - t0) >= 0 : $signed(cap_t[base] - t0) >= 0,
              {ctx, " R3 no early release"}, cap_t[base], t0);
      end
      check(drop_cnt == drops0, {ctx, " R6 no drop on future packet"}, 32'(drop_cnt), 32'(drops0));
    end
  endtask

  initial begin
    logic [31:0] now0;
    int          b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(smp_valid == 1'b0, "R1 smp_valid after reset", 32'(smp_valid), 32'd0);
    check(drop_cnt == 16'd0, "R1 drop_cnt after reset", 32'(drop_cnt), 32'd0);
    check(wr_ready == 1'b1, "R1 wr_ready after reset", 32'(wr_ready), 32'd1);

    // R3 exact launch with latency 3
    tick_mode = 0;
    pipe_lat  = 16'd3;
    run_pkt(time_now + 32'd40, 16'd5, 16'h0000, "directed", 1'b1);

    // R2 flags word all ones changes nothing
    pipe_lat = 16'd7;
    run_pkt(time_now + 32'd45, 16'd4, 16'hFFFF, "R2 flags", 1'b1);

    // R5 one sample per enable: enables every third cycle
    tick_mode = 1;
    pipe_lat  = 16'd0;
    run_pkt(time_now + 32'd40, 16'd6, 16'h1234, "R5 sparse tick", 1'b0);
    for (int k = 1; k < 6; k++)
      check(cap_t[last_base + k] - cap_t[last_base + k - 1] == 32'd3, "R5 sample spacing",
            cap_t[last_base + k] - cap_t[last_base + k - 1], 32'd3);
    tick_mode = 0;

    // R6 stale packet, then a good packet proves its words were skipped
    pipe_lat = 16'd2;
    run_pkt(time_now - 32'd30, 16'd6, 16'h0001, "R6 stale", 1'b0);
    run_pkt(time_now + 32'd35, 16'd3, 16'h0000, "R6 after skip", 1'b1);

    // R9 zero count
    run_pkt(time_now + 32'd30, 16'd0, 16'h0000, "R9 zero count", 1'b0);
    run_pkt(time_now + 32'd30, 16'd2, 16'h0000, "R9 follow-up", 1'b1);

    // R7 wraparound: future across the rollover, then stale across it
    time_base = 32'hFFFF_FFC0 - cyc;
    @(negedge clk);
    run_pkt(32'h0000_0030, 16'd3, 16'h0000, "R7 future across wrap", 1'b1);
    check(time_now < 32'h0000_1000, "R7 time wrapped", time_now, 32'h0000_1000);
    run_pkt(32'hFFFF_FFF0, 16'd2, 16'h0000, "R7 stale across wrap", 1'b0);

    // R8 full store and R10 back-to-back packets
    pipe_lat = 16'd0;
    now0 = time_now;
    b    = ncap;
    fill_samples(6);
    send_pkt(now0 + 32'd200, 16'd6, 16'h0000);
    put_word(16'(now0 + 32'd220));
    put_word(16'((now0 + 32'd220) >> 16));
    put_word(16'd2);
    put_word(16'h0000);
    check(wr_ready == 1'b0, "R8 ready low when full", 32'(wr_ready), 32'd0);
    wr_valid = 1'b1;
    wr_data  = 16'hDEAD;
    repeat (5) @(negedge clk);
    wr_valid = 1'b0;
    check(wr_ready == 1'b0, "R8 still full after blocked writes", 32'(wr_ready), 32'd0);
    for (int k = 0; k < 2; k++) begin
      put_word(16'h2000 + 16'(k));
      put_word(16'h3000 + 16'(k));
    end
    for (int w = 0; w < 2000 && ncap < b + 8; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(ncap == b + 8, "R10 back-to-back count", 32'(ncap - b), 32'd8);
    for (int k = 0; k < 6; k++)
      check(cap_i[b + k] == pk_i[k] && cap_q[b + k] == pk_q[k], "R8 first packet intact",
            {cap_i[b + k], cap_q[b + k]}, {pk_i[k], pk_q[k]});
    for (int k = 0; k < 2; k++)
      check(cap_i[b + 6 + k] == 16'h2000 + 16'(k) && cap_q[b + 6 + k] == 16'h3000 + 16'(k),
            "R8 blocked junk not stored, R10 order",
            {cap_i[b + 6 + k], cap_q[b + 6 + k]}, {16'h2000 + 16'(k), 16'h3000 + 16'(k)});
    check(cap_t[b] == now0 + 32'd202, "R3 first packet time", cap_t[b], now0 + 32'd202);
    check(cap_t[b + 6] == now0 + 32'd222, "R10 second packet time", cap_t[b + 6], now0 + 32'd222);

    // Random mix
    for (int n = 0; n < 24; n++) begin
      logic [15:0] cnt;
      logic [31:0] ts;
      bit          old;
      tick_mode = $urandom % 3;
      pipe_lat  = 16'($urandom % 16);
      cnt       = 16'($urandom % 7);
      old       = ($urandom % 4) == 0;
      if (old) ts = time_now + 32'(pipe_lat) - 32'd10 - 32'($urandom % 50);
      else     ts = time_now + 32'(pipe_lat) + 32'd30 + 32'($urandom % 40);
      run_pkt(ts, cnt, 16'($urandom), "random", tick_mode == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule